// File: doc/BRIEF.md
# Low-Side Overcurrent Strike Filter

This block sits between a sampled low-side current comparator and the gate-drive sequencer of a synchronous buck converter. Once per switching period it decides whether the comparator reported an overcurrent. The comparator is trusted only after the blanking window of that period has ended. When a genuine event is seen, the block asks the high-side driver to hold off. The hold stays on until a new period begins while the comparator is quiet, so pulses are skipped for as long as the overcurrent persists.

Each period that contains an event adds one strike. When the strike total reaches a limit, the block emits a one-clock fault pulse that the fault sequencer turns into a hiccup restart. A run of clean periods clears the strikes. That run restarts from zero every time a new strike lands. The block also passes on a select that switches the current limit to a fixed fallback threshold when the set-resistor pin is flagged as clamped.

Top module: `ocp_strike_filter`

## Requirements
- R1: While `blank_done` is low, a high `cmp_trip` neither adds a strike nor sets `hs_hold`. In the clock where `cyc_strobe` is high, the comparator is not sampled either.
- R2: No more than one strike is counted between two consecutive `cyc_strobe` pulses, however many clocks `cmp_trip` stays high.
- R3: A qualified event (enabled, `blank_done`=1, `cmp_trip`=1, no strobe, first in the period) sets `hs_hold` to 1 on the next clock.
- R4: `hs_hold` drops to 0 on the clock after a `cyc_strobe` that arrives while `cmp_trip` is 0. A strobe that arrives while `cmp_trip` is 1 leaves it at 1.
- R5: `strike_cnt` increases by one on the clock after each qualified event that does not complete the limit.
- R6: The qualified event that brings the strikes to STRIKE_LIMIT (default 3) gives a one-clock `ocp_fault`=1 on the next clock, and `strike_cnt` returns to 0 at the same time. `strike_cnt` never reaches STRIKE_LIMIT.
- R7: A period is clean when no strike landed between two strobes. While `strike_cnt` is nonzero, the strobe that closes the CLEAN_LIMIT-th (default 7) consecutive clean period clears `strike_cnt` on the next clock. Any strike restarts the clean run from zero.
- R8: When `enable` is 0 or `hiccup` is 1, the next clock clears `strike_cnt`, `hs_hold`, the clean run and the per-period event memory, and `ocp_fault` stays 0.
- R9: `fixed_thr_sel` equals the value `iset_clamped` had one clock earlier, whatever the enable state.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Converter enabled; 0 clears the block |
| hiccup | input | 1 | Fault sequencer is in hiccup; 1 clears the block |
| cyc_strobe | input | 1 | One-clock pulse at the start of each switching period |
| blank_done | input | 1 | Blanking window of the current period has elapsed |
| cmp_trip | input | 1 | Low-side overcurrent comparator result |
| iset_clamped | input | 1 | Set-resistor pin has reached its clamp (resistor missing) |
| hs_hold | output | 1 | Keep the high-side switch off |
| ocp_fault | output | 1 | One-clock pulse requesting hiccup |
| strike_cnt | output | $clog2(STRIKE_LIMIT+1) | Consecutive strike count |
| fixed_thr_sel | output | 1 | Use the fixed fallback threshold |

## Verification
The bench builds the block with its default limits: three strikes and seven clean periods. With these values a fault is reached in three trip periods, and a full clean-run expiry takes eight strobes after a trip. So the off-by-one edges of both counters can be checked directly: six clean periods must keep the count and the seventh must clear it. A clean run that a fresh strike interrupts is also checked. Short periods of six to twelve clocks let a few hundred randomised periods reach every hold, strike and clear path many times.

// File: rtl/ocp_filt_pkg.sv
package ocp_filt_pkg;

  // True when adding one strike to cnt_now reaches the limit.
  function automatic logic strike_reaches(input int cnt_now, input int limit);
    return (cnt_now + 1) >= limit;
  endfunction

  // True when one more clean period completes the clean run.
  function automatic logic clean_expires(input int run_now, input int limit);
    return (run_now + 1) >= limit;
  endfunction

endpackage

// File: rtl/ocp_trip_qual.sv
module ocp_trip_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cyc_strobe,
  input  logic blank_done,
  input  logic cmp_trip,
  output logic trip_ev,
  output logic period_tripped
);

  logic seen_q;

  // A strobe clock starts a new period and is never sampled.
  assign trip_ev        = active & blank_done & cmp_trip & ~cyc_strobe & ~seen_q;
  assign period_tripped = seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_q <= 1'b0;
    else if (!active)    seen_q <= 1'b0;
    else if (cyc_strobe) seen_q <= 1'b0;
    else if (trip_ev)    seen_q <= 1'b1;
  end

endmodule

// File: rtl/ocp_hs_hold.sv
module ocp_hs_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic trip_ev,
  input  logic cyc_strobe,
  input  logic cmp_trip,
  output logic hs_hold
);

  logic release_now;

  assign release_now = cyc_strobe & ~cmp_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hs_hold <= 1'b0;
    else if (!active)     hs_hold <= 1'b0;
    else if (trip_ev)     hs_hold <= 1'b1;
    else if (release_now) hs_hold <= 1'b0;
  end

endmodule

// File: rtl/ocp_strike_ctr.sv
module ocp_strike_ctr
  import ocp_filt_pkg::*;
#(
  parameter int STRIKE_LIMIT = 3,
  parameter int CLEAN_LIMIT  = 7,
  localparam int SW  = $clog2(STRIKE_LIMIT + 1),
  localparam int CLW = $clog2(CLEAN_LIMIT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           trip_ev,
  input  logic           cyc_strobe,
  input  logic           period_tripped,
  output logic [SW-1:0]  strike_cnt,
  output logic [CLW-1:0] clean_run,
  output logic           ocp_fault,
  output logic           limit_hit,
  output logic           clean_expire
);

  logic clean_close;

  // A strobe closes a period; it is clean if no strike landed in it.
  assign clean_close  = cyc_strobe & ~period_tripped & (strike_cnt != '0);
  assign limit_hit    = trip_ev & strike_reaches(int'(strike_cnt), STRIKE_LIMIT);
  assign clean_expire = clean_close & clean_expires(int'(clean_run), CLEAN_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strike_cnt <= '0;
      clean_run  <= '0;
      ocp_fault  <= 1'b0;
    end else if (!active) begin
      strike_cnt <= '0;
      clean_run  <= '0;
      ocp_fault  <= 1'b0;
    end else begin
      ocp_fault <= limit_hit;
      if (trip_ev) begin
        clean_run  <= '0;
        strike_cnt <= limit_hit ? '0 : strike_cnt + SW'(1);
      end else if (cyc_strobe) begin
        if (clean_expire) begin
          strike_cnt <= '0;
          clean_run  <= '0;
        end else if (clean_close) begin
          clean_run <= clean_run + CLW'(1);
        end else begin
          clean_run <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/ocp_strike_filter.sv
module ocp_strike_filter #(
  parameter int STRIKE_LIMIT = 3,
  parameter int CLEAN_LIMIT  = 7,
  localparam int SW  = $clog2(STRIKE_LIMIT + 1),
  localparam int CLW = $clog2(CLEAN_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          hiccup,
  input  logic          cyc_strobe,
  input  logic          blank_done,
  input  logic          cmp_trip,
  input  logic          iset_clamped,
  output logic          hs_hold,
  output logic          ocp_fault,
  output logic [SW-1:0] strike_cnt,
  output logic          fixed_thr_sel
);

  logic           active;
  logic           trip_ev;
  logic           period_tripped;
  logic [CLW-1:0] clean_run;
  logic           limit_hit;
  logic           clean_expire;

  assign active = enable & ~hiccup;

  ocp_trip_qual u_qual (
    .clk            (clk),
    .rst_n          (rst_n),
    .active         (active),
    .cyc_strobe     (cyc_strobe),
    .blank_done     (blank_done),
    .cmp_trip       (cmp_trip),
    .trip_ev        (trip_ev),
    .period_tripped (period_tripped)
  );

  ocp_hs_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .trip_ev    (trip_ev),
    .cyc_strobe (cyc_strobe),
    .cmp_trip   (cmp_trip),
    .hs_hold    (hs_hold)
  );

  ocp_strike_ctr #(
    .STRIKE_LIMIT (STRIKE_LIMIT),
    .CLEAN_LIMIT  (CLEAN_LIMIT)
  ) u_ctr (
    .clk            (clk),
    .rst_n          (rst_n),
    .active         (active),
    .trip_ev        (trip_ev),
    .cyc_strobe     (cyc_strobe),
    .period_tripped (period_tripped),
    .strike_cnt     (strike_cnt),
    .clean_run      (clean_run),
    .ocp_fault      (ocp_fault),
    .limit_hit      (limit_hit),
    .clean_expire   (clean_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fixed_thr_sel <= 1'b0;
    else        fixed_thr_sel <= iset_clamped;
  end

endmodule

// File: rtl/ocp_strike_filter_chk.sv
module ocp_strike_filter_chk #(
  parameter int STRIKE_LIMIT = 3,
  parameter int CLEAN_LIMIT  = 7,
  localparam int SW  = $clog2(STRIKE_LIMIT + 1),
  localparam int CLW = $clog2(CLEAN_LIMIT + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           hiccup,
  input logic           cyc_strobe,
  input logic           blank_done,
  input logic           cmp_trip,
  input logic           iset_clamped,
  input logic           hs_hold,
  input logic           ocp_fault,
  input logic [SW-1:0]  strike_cnt,
  input logic           fixed_thr_sel,
  input logic           trip_ev,
  input logic [CLW-1:0] clean_run
);

  // R1
  no_early_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_done || cyc_strobe) |-> !trip_ev);

  // R2
  one_event_per_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_ev |=> !trip_ev);

  // R3
  hold_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_ev |=> hs_hold);

  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_hold && enable && !hiccup && cyc_strobe && !cmp_trip) |=> !hs_hold);

  // R6
  fault_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_fault |-> ($past(trip_ev) && ($past(strike_cnt) == SW'(STRIKE_LIMIT - 1)) && strike_cnt == '0));

  // R6
  strike_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(strike_cnt) < STRIKE_LIMIT);

  // R7
  clean_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(clean_run) < CLEAN_LIMIT);

  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || hiccup) |=> (strike_cnt == '0 && !hs_hold && !ocp_fault && clean_run == '0));

  // R9
  sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fixed_thr_sel == $past(iset_clamped)));

endmodule

bind ocp_strike_filter ocp_strike_filter_chk #(
  .STRIKE_LIMIT (STRIKE_LIMIT),
  .CLEAN_LIMIT  (CLEAN_LIMIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .hiccup        (hiccup),
  .cyc_strobe    (cyc_strobe),
  .blank_done    (blank_done),
  .cmp_trip      (cmp_trip),
  .iset_clamped  (iset_clamped),
  .hs_hold       (hs_hold),
  .ocp_fault     (ocp_fault),
  .strike_cnt    (strike_cnt),
  .fixed_thr_sel (fixed_thr_sel),
  .trip_ev       (trip_ev),
  .clean_run     (clean_run)
);

// File: tb/sim_ocp_strike_filter.sv
module sim_ocp_strike_filter;

  localparam int STRIKES = 3;
  localparam int CLEANS  = 7;

  logic clk = 1'b0;
  logic rst_n, en, hic, stb, bd, cmp, iso;
  logic hs_hold, ocp_fault, fixed_thr_sel;
  logic [1:0] strike_cnt;

  int n_checks = 0;
  int n_fail   = 0;
  int faults_seen = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0, m_clean = 0, m_seen = 0, m_hold = 0, m_fault = 0, m_sel = 0;

  always #4 clk = ~clk;

  ocp_strike_filter u0 (
    .clk(clk), .rst_n(rst_n), .enable(en), .hiccup(hic), .cyc_strobe(stb),
    .blank_done(bd), .cmp_trip(cmp), .iset_clamped(iso),
    .hs_hold(hs_hold), .ocp_fault(ocp_fault), .strike_cnt(strike_cnt),
    .fixed_thr_sel(fixed_thr_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_clean = 0; m_seen = 0; m_hold = 0; m_fault = 0; m_sel = 0;
    end else begin
      bit live, hit;
      m_sel = iso;
      live = en && !hic;
      if (!live) begin
        m_cnt = 0; m_clean = 0; m_seen = 0; m_hold = 0; m_fault = 0;
      end else begin
        hit = bd && cmp && !stb && (m_seen == 0);
        m_fault = 0;
        if (hit) begin
          m_hold = 1;
          m_seen = 1;
          m_clean = 0;
          if (m_cnt + 1 == STRIKES) begin m_cnt = 0; m_fault = 1; end
          else m_cnt = m_cnt + 1;
        end else if (stb) begin
          if (!cmp) m_hold = 0;
          if (m_seen == 0 && m_cnt > 0) begin
            m_clean = m_clean + 1;
            if (m_clean == CLEANS) begin m_cnt = 0; m_clean = 0; end
          end else m_clean = 0;
          m_seen = 0;
        end
      end
    end
  end

  // Compare on every falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk(hs_hold == m_hold[0], "R3/R4 hs_hold", hs_hold, m_hold);
      chk(int'(strike_cnt) == m_cnt, "R5/R7 strike_cnt", strike_cnt, m_cnt);
      chk(ocp_fault == m_fault[0], "R6 ocp_fault", ocp_fault, m_fault);
      chk(fixed_thr_sel == m_sel[0], "R9 fixed_thr_sel", fixed_thr_sel, m_sel);
      if (ocp_fault) faults_seen++;
    end
  end

  task automatic run_period(input int len, input int blank_at, input int tf, input int tt);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      stb = (i == 0);
      bd  = (i >= blank_at);
      cmp = (i >= tf) && (i < tt);
    end
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic clear_block();
    @(negedge clk); en = 1'b0; stb = 0; bd = 0; cmp = 0;
    @(negedge clk); en = 1'b1;
  endtask

  initial begin
    rst_n = 0; en = 1; hic = 0; stb = 0; bd = 0; cmp = 0; iso = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(hs_hold == 0 && ocp_fault == 0 && strike_cnt == 0 && fixed_thr_sel == 0,
        "R10 reset outputs", {hs_hold, ocp_fault, strike_cnt, fixed_thr_sel}, 0);
    rst_n = 1;

    // R1: comparator high but blanking never ends
    run_period(10, 20, 2, 9); settle();
    chk(strike_cnt == 0, "R1 count before blanking", strike_cnt, 0);
    chk(hs_hold == 0, "R1 hold before blanking", hs_hold, 0);

    // R2/R3/R5: long trip inside one period
    run_period(10, 3, 3, 10); settle();
    chk(strike_cnt == 1, "R2 one strike per period", strike_cnt, 1);
    chk(hs_hold == 1, "R3 hold after event", hs_hold, 1);

    // R4: comparator still high at the next strobe keeps hold
    run_period(10, 3, 0, 2); settle();
    chk(hs_hold == 1, "R4 hold kept while comparator high", hs_hold, 1);
    chk(strike_cnt == 1, "R5 no strike without qualified event", strike_cnt, 1);
    run_period(10, 3, 20, 20); settle();
    chk(hs_hold == 0, "R4 hold released at quiet strobe", hs_hold, 0);

    // R8: disable clears
    run_period(10, 3, 4, 6);
    @(negedge clk); en = 0; stb = 0; bd = 0; cmp = 0;
    settle();
    chk(strike_cnt == 0 && hs_hold == 0, "R8 disable clears", {strike_cnt, hs_hold}, 0);
    @(negedge clk); en = 1;

    // R7: six clean periods keep the strike, the seventh clears it
    run_period(10, 3, 4, 6);
    for (int k = 0; k < 7; k++) run_period(10, 3, 20, 20);
    settle();
    chk(strike_cnt == 1, "R7 six clean periods keep count", strike_cnt, 1);
    run_period(10, 3, 20, 20); settle();
    chk(strike_cnt == 0, "R7 seventh clean period clears", strike_cnt, 0);

    // R7: a fresh strike restarts the clean run
    clear_block();
    run_period(10, 3, 4, 6);
    for (int k = 0; k < 5; k++) run_period(10, 3, 20, 20);
    run_period(10, 3, 4, 6);
    for (int k = 0; k < 7; k++) run_period(10, 3, 20, 20);
    settle();
    chk(strike_cnt == 2, "R7 clean run restarted by strike", strike_cnt, 2);
    run_period(10, 3, 20, 20); settle();
    chk(strike_cnt == 0, "R7 restarted run expires", strike_cnt, 0);

    // R6: three trip periods raise the fault
    @(negedge clk); hic = 1; @(negedge clk); hic = 0;
    chk(strike_cnt == 0, "R8 hiccup clears", strike_cnt, 0);
    begin
      int f0;
      f0 = faults_seen;
      for (int k = 0; k < 3; k++) run_period(10, 3, 5, 7);
      run_period(4, 3, 20, 20); settle();
      chk(faults_seen - f0 == 1, "R6 single fault pulse", faults_seen - f0, 1);
      chk(strike_cnt == 0, "R6 count cleared by fault", strike_cnt, 0);
    end

    // R9: fallback select
    @(negedge clk); iso = 1; settle();
    chk(fixed_thr_sel == 1, "R9 select follows clamp", fixed_thr_sel, 1);
    @(negedge clk); iso = 0; en = 0; settle();
    chk(fixed_thr_sel == 0, "R9 select follows clamp while disabled", fixed_thr_sel, 0);
    @(negedge clk); en = 1;

    // Randomised periods, compared every clock against the model
    for (int p = 0; p < 300; p++) begin
      int len, ba, tf, tt;
      len = 6 + int'($urandom_range(6));
      ba  = 2 + int'($urandom_range(2));
      tf  = int'($urandom_range(len));
      tt  = tf + int'($urandom_range(len));
      iso = $urandom_range(1);
      en  = ($urandom_range(19) != 0);
      hic = ($urandom_range(29) == 0);
      run_period(len, ba, tf, tt);
    end

    @(negedge clk); done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule